// File: doc/BRIEF.md
# SPDIF Subframe Biphase Encoder

This block serialises audio samples into a biphase-mark coded SPDIF line. It runs from the audio master clock, which the block divides by 2, 3 or 4 according to the oversampling ratio (256, 384 or 512 times the sample rate). Each divided tick is one half-cell (unit interval), so one frame of two subframes lasts 128 unit intervals, which is one sample period.

Samples arrive as LSB-justified 32-bit words through a two-entry ping-pong store. A request line is raised whenever either entry is empty, so that a DMA engine can keep the store filled. At the start of every subframe one word is taken, left channel first and then right. Only the selected low 16, 20 or 24 bits are kept. A subframe carries a preamble, 24 audio slots, a validity bit, a user bit, one bit of a 192-bit channel-status word and an even parity bit. When no sample is waiting, the subframe carries silence and is flagged as invalid.

Top module: `spdif_tx`

## Requirements
- R1: One unit interval lasts 2, 3 or 4 master clock cycles for `ratio_sel` equal to 0, 1, or 2 and 3 respectively. So the first preamble's first falling edge comes 3 unit intervals after its first rising edge.
- R2: A subframe has 64 unit intervals, which form 32 slots of two intervals each. From slot 4 on, the line toggles at every slot boundary, and it toggles again mid-slot exactly when the slot carries a one. Audio slots 4..27 carry the 24-bit audio field LSB first.
- R3: Slots 0..3 hold a preamble, sent as 8 intervals relative to the level just before it (1 means the opposite level). 11101000 opens the left subframe of frame 0, 11100010 opens the other left subframes, and 11100100 opens every right subframe.
- R4: With `width_sel` 0 the audio field is word[15:0] followed by 8 zero bits. With 1 it is word[19:0] followed by 4 zero bits. With 2 or 3 it is word[23:0]. Bits above the width have no effect.
- R5: Slot 28 (validity) is 0 for a subframe carrying a buffered sample, and slot 29 (user) is always 0.
- R6: Slot 30 of both subframes of frame f carries `chan_status[f]`. Frames count from 0 to 191 and then return to 0.
- R7: Slot 31 makes the count of ones in slots 4..31 even.
- R8: The store holds two words. `dma_req` is high exactly when at least one entry is empty. A write while both entries are full is dropped. Words leave in write order.
- R9: If no word is stored when a subframe starts, the audio field is zero and validity is 1.
- R10: During reset `spdif_out` is 0 and `dma_req` is 1, and the first subframe after reset is the left subframe of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | 2 | Master clock ratio: 0 = 256fs, 1 = 384fs, 2 or 3 = 512fs |
| width_sel | input | 2 | Sample width: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| chan_status | input | FRAMES (192) | Channel-status bits, one per frame index |
| wr_en | input | 1 | Write strobe into the sample store |
| wr_data | input | WORD_W (32) | LSB-justified sample word |
| dma_req | output | 1 | High while a store entry is empty |
| spdif_out | output | 1 | Biphase-mark serial output |

## Verification
The encoder is driven with 24-bit words at ratio 256fs, 16-bit words at 384fs and 20-bit words at 512fs. Every word has junk in its upper bits. Because width and divider change together, a wrong alignment, a wrong divider and upper-bit leakage each give a different wrong decode. Each stream runs out of samples partway, so real and underrun subframes are compared in one capture. A run of more than one block with almost no samples separates the block-start preamble from the other left preambles and shows the channel-status index wrapping. A hand-timed burst of three writes against a full store shows that the third word is dropped rather than overwriting one that is still pending.

// File: rtl/spdif_tx.sv
module spdif_tx #(
  parameter int FRAMES = 192,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ratio_sel,
  input  logic [1:0]        width_sel,
  input  logic [FRAMES-1:0] chan_status,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              dma_req,
  output logic              spdif_out
);
  localparam int FCW   = $clog2(FRAMES);
  localparam int AUD_W = 24;
  localparam logic [7:0] PAT_BLK   = 8'b11101000;
  localparam logic [7:0] PAT_LEFT  = 8'b11100010;
  localparam logic [7:0] PAT_RIGHT = 8'b11100100;

  logic [1:0]        div_cnt, div_last;
  logic              tick, load, pop, push;
  logic [5:0]        pos;
  logic [4:0]        slot, aidx;
  logic              sub;
  logic [FCW-1:0]    frame;
  logic [WORD_W-1:0] mem [2];
  logic [WORD_W-1:0] rd_word;
  logic [1:0]        full;
  logic              wptr, rptr;
  logic [AUD_W-1:0]  aud, aligned;
  logic              vbit, pre_lvl, cs_bit, dbit;
  logic [7:0]        pat;

  assign div_last = (ratio_sel == 2'd0) ? 2'd1 : (ratio_sel == 2'd1) ? 2'd2 : 2'd3;
  assign tick     = div_cnt >= div_last;
  assign slot     = pos[5:1];
  assign aidx     = slot - 5'd4;
  assign load     = tick && (pos == 6'd0);
  assign pop      = load && full[rptr];
  assign push     = wr_en && !full[wptr];
  assign dma_req  = !(full[0] && full[1]);
  assign rd_word  = mem[rptr];
  assign cs_bit   = chan_status[frame];
  assign pat      = sub ? PAT_RIGHT : ((frame == '0) ? PAT_BLK : PAT_LEFT);

  always_comb begin
    case (width_sel)
      2'd0:    aligned = {rd_word[15:0], 8'h00};
      2'd1:    aligned = {rd_word[19:0], 4'h0};
      default: aligned = rd_word[AUD_W-1:0];
    endcase
  end

  always_comb begin
    case (slot)
      5'd28:   dbit = vbit;
      5'd29:   dbit = 1'b0;
      5'd30:   dbit = cs_bit;
      5'd31:   dbit = ^aud ^ vbit ^ cs_bit;
      default: dbit = (slot >= 5'd4) ? aud[aidx] : 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      pos     <= '0;
      sub     <= 1'b0;
      frame   <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      pos     <= pos + 6'd1;
      if (pos == 6'd63) begin
        sub <= ~sub;
        if (sub) frame <= (frame == FCW'(FRAMES - 1)) ? '0 : frame + 1'b1;
      end
    end else begin
      div_cnt <= div_cnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= '0;
      wptr <= 1'b0;
      rptr <= 1'b0;
    end else begin
      if (push) begin
        full[wptr] <= 1'b1;
        wptr       <= ~wptr;
      end
      if (pop) begin
        full[rptr] <= 1'b0;
        rptr       <= ~rptr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aud  <= '0;
      vbit <= 1'b1;
    end else if (load) begin
      aud  <= pop ? aligned : '0;
      vbit <= !pop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spdif_out <= 1'b0;
      pre_lvl   <= 1'b0;
    end else if (tick) begin
      if (slot < 5'd4) begin
        if (pos == 6'd0) begin
          pre_lvl   <= spdif_out;
          spdif_out <= spdif_out ^ pat[7];
        end else begin
          spdif_out <= pre_lvl ^ pat[3'd7 - pos[2:0]];
        end
      end else if (!pos[0]) begin
        spdif_out <= ~spdif_out;
      end else begin
        spdif_out <= spdif_out ^ dbit;
      end
    end
  end
endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk #(
  parameter int FCW    = 8,
  parameter int FRAMES = 192
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic [5:0]     pos,
  input logic           spdif_out,
  input logic           dma_req,
  input logic [1:0]     full,
  input logic           load,
  input logic           vbit,
  input logic [FCW-1:0] frame
);
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(spdif_out));

  a_r2_cell_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pos >= 6'd8 && !pos[0]) |=> (spdif_out != $past(spdif_out)));

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && !load) |=> !dma_req);

  a_r9_underrun_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (load && full == 2'b00) |=> vbit);

  a_r6_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frame) < FRAMES);
endmodule

bind spdif_tx spdif_tx_chk #(.FCW(FCW), .FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pos(pos), .spdif_out(spdif_out),
  .dma_req(dma_req), .full(full), .load(load), .vbit(vbit), .frame(frame)
);

// File: tb/spdif_tx_tb_top.sv
module spdif_tx_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   ratio_sel = 2'd0;
  logic [1:0]   width_sel = 2'd2;
  logic [191:0] chan_status = {6{32'hA5C3_1E97}};
  logic         wr_en;
  logic [31:0]  wr_data;
  logic         dma_req, spdif_out;

  always #5 clk = ~clk;

  spdif_tx dut_i (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .width_sel(width_sel),
    .chan_status(chan_status), .wr_en(wr_en), .wr_data(wr_data),
    .dma_req(dma_req), .spdif_out(spdif_out)
  );

  int n_chk = 0, n_fail = 0;
  int cur_div = 2;

  // feeder and manual drive
  logic        feed_on = 1'b0, f_en = 1'b0, m_en = 1'b0;
  logic [31:0] f_data = '0, m_data = '0;
  logic [31:0] samp [16];
  int          fidx = 0, nfeed = 0;
  assign wr_en   = feed_on ? f_en : m_en;
  assign wr_data = feed_on ? f_data : m_data;

  always @(negedge clk) begin
    if (!rst_n || !feed_on) f_en = 1'b0;
    else if (dma_req && fidx < nfeed) begin
      f_en = 1'b1; f_data = samp[fidx]; fidx++;
    end else f_en = 1'b0;
  end

  // line sampler and decoder
  logic       lv [64];
  logic       prevl, synced;
  int         ui, cyc, since, fall_cyc, sf_n;
  logic [1:0] r_pre [400];
  logic [23:0] r_aud [400];
  logic       r_v [400], r_u [400], r_c [400], r_p [400], r_ok [400];

  task automatic decode_sf();
    logic [7:0]  rel;
    logic [31:0] bits;
    logic        ok;
    for (int k = 0; k < 8; k++) rel[7-k] = lv[k] ^ prevl;
    ok = 1'b1; bits = '0;
    for (int k = 4; k < 32; k++) begin
      if (lv[2*k] == lv[2*k-1]) ok = 1'b0;
      bits[k] = lv[2*k] ^ lv[2*k+1];
    end
    if (sf_n < 400) begin
      r_pre[sf_n] = (rel == 8'b11101000) ? 2'd0 : (rel == 8'b11100010) ? 2'd1 :
                    (rel == 8'b11100100) ? 2'd2 : 2'd3;
      r_aud[sf_n] = bits[27:4];
      r_v[sf_n] = bits[28]; r_u[sf_n] = bits[29];
      r_c[sf_n] = bits[30]; r_p[sf_n] = bits[31];
      r_ok[sf_n] = ok;
    end
    prevl = lv[63];
    sf_n++;
    ui = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      synced = 1'b0; prevl = 1'b0; ui = 0; cyc = 0; since = 0; fall_cyc = -1; sf_n = 0;
    end else if (!synced) begin
      if (spdif_out) begin
        synced = 1'b1; lv[0] = 1'b1; ui = 1; cyc = 0; since = 0;
      end
    end else begin
      cyc++; since++;
      if (fall_cyc < 0 && !spdif_out) fall_cyc = since;
      if (cyc == cur_div) begin
        cyc = 0;
        lv[ui] = spdif_out;
        ui++;
        if (ui == 64) decode_sf();
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_field(input logic [1:0] w, input logic [31:0] s);
    if (w == 2'd0) return {s[15:0], 8'h00};
    if (w == 2'd1) return {s[19:0], 4'h0};
    return s[23:0];
  endfunction

  task automatic do_reset(input logic [1:0] r, input logic [1:0] w);
    rst_n = 1'b0; ratio_sel = r; width_sel = w;
    cur_div = (r == 2'd0) ? 2 : (r == 2'd1) ? 3 : 4;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wait_sf(input int n);
    while (sf_n < n) @(negedge clk);
  endtask

  task automatic check_sf(input int i, input logic [1:0] w, input bit has_data,
                          input logic [31:0] s);
    int f; logic [1:0] ep; logic [23:0] ea; logic par;
    f  = (i / 2) % 192;
    ep = (i % 2 == 1) ? 2'd2 : (f == 0 ? 2'd0 : 2'd1);
    ea = has_data ? exp_field(w, s) : 24'h0;
    chk(r_pre[i] == ep, "R3", $sformatf("preamble sf%0d", i), r_pre[i], ep);
    chk(r_ok[i], "R2", $sformatf("cell boundary sf%0d", i), r_ok[i], 1);
    chk(r_aud[i] == ea, has_data ? "R4" : "R9", $sformatf("audio sf%0d", i), r_aud[i], ea);
    chk(r_v[i] == !has_data, has_data ? "R5" : "R9", $sformatf("validity sf%0d", i), r_v[i], !has_data);
    chk(r_u[i] == 1'b0, "R5", $sformatf("user sf%0d", i), r_u[i], 0);
    chk(r_c[i] == chan_status[f], "R6", $sformatf("cs sf%0d", i), r_c[i], chan_status[f]);
    par = ^{r_aud[i], r_v[i], r_u[i], r_c[i], r_p[i]};
    chk(par == 1'b0, "R7", $sformatf("parity sf%0d", i), par, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; feed_on = 1'b0; m_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(spdif_out == 1'b0, "R10", "line in reset", spdif_out, 0);
    chk(dma_req == 1'b1, "R10", "request in reset", dma_req, 1);
  endtask

  task automatic t_stream(input logic [1:0] r, input logic [1:0] w, input int nf, input int nframes);
    for (int i = 0; i < 16; i++)
      samp[i] = (32'h9E37_79B9 * (i + 1)) ^ {8'hC5, 24'h0};
    feed_on = 1'b1; fidx = 0; nfeed = nf;
    do_reset(r, w);
    wait_sf(2 * nframes);
    feed_on = 1'b0;
    chk(fall_cyc == 3 * cur_div, "R1", $sformatf("interval length ratio %0d", r), fall_cyc, 3 * cur_div);
    for (int i = 0; i < 2 * nframes; i++) check_sf(i, w, i < nf, samp[i % 16]);
  endtask

  task automatic t_drop();
    logic [31:0] a, b, c;
    a = 32'h1234_5678; b = 32'hFEDC_BA98; c = 32'h0F0F_0F0F;
    feed_on = 1'b0; m_en = 1'b1; m_data = a;
    do_reset(2'd2, 2'd2);
    @(posedge clk); #1 m_data = b;
    @(posedge clk); #1 m_data = c;
    @(posedge clk); #1 m_en = 1'b0;
    @(negedge clk);
    chk(dma_req == 1'b0, "R8", "request with both full", dma_req, 0);
    @(negedge clk);
    chk(dma_req == 1'b1, "R8", "request after first take", dma_req, 1);
    wait_sf(4);
    check_sf(0, 2'd2, 1'b1, a);
    check_sf(1, 2'd2, 1'b1, b);
    chk(r_v[2] == 1'b1 && r_aud[2] == 24'h0, "R8", "third write dropped", r_aud[2], 0);
    check_sf(3, 2'd2, 1'b0, '0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 16; i++) samp[i] = 32'h0055_AA00 + i;
    feed_on = 1'b1; fidx = 0; nfeed = 2;
    do_reset(2'd0, 2'd2);
    wait_sf(386);
    feed_on = 1'b0;
    for (int i = 0; i < 386; i++) check_sf(i, 2'd2, i < 2, samp[i % 16]);
    chk(r_pre[384] == 2'd0, "R6", "block restart preamble", r_pre[384], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_stream(2'd0, 2'd2, 8, 6);
    t_stream(2'd1, 2'd0, 8, 6);
    t_stream(2'd2, 2'd1, 8, 6);
    t_stream(2'd3, 2'd2, 3, 3);
    t_drop();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule